// File: doc/BRIEF.md
# Conversion Result Buffer with Temperature Slot

This block holds the results produced by a converter until a serial port reads them. It keeps up to sixteen 12-bit conversion results in arrival order, plus one separate register for the latest temperature result. A one-cycle write strobe loads a result. A flag on that strobe decides whether the value goes into the queue or into the temperature register.

The serial side raises a one-cycle pop request each time a new read transaction starts. On that request the buffer removes one item and places it in a 16-bit output register. The word has four zero bits above the 12-bit value, so a shifter can send it MSB first. A waiting temperature result always goes out before any queued result. When nothing is stored, the popped word is zero.

The buffer never blocks the converter. A result that arrives while the queue is full takes the place of the oldest one. A synchronous flush empties the queue and the temperature register.

Top module: `conv_result_fifo`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, `fillLevel` is 0, `tempHeld` is 0 and `outWord` is 0x0000.
- R2: A pop request loads `outWord` at the next clock edge with the oldest queued result, and results leave in the order they were written. `outWord` holds its value while there is no pop and no flush.
- R3: `outWord[15:12]` is always zero and `outWord[11:0]` carries the 12-bit result.
- R4: A pop with no temperature result and an empty queue loads 0x0000 and leaves `fillLevel` at 0.
- R5: While `tempHeld` is 1, a pop loads the temperature value and clears `tempHeld`. The queue is left untouched.
- R6: A temperature write (`wrIsTemp`=1) replaces any unread temperature value and sets `tempHeld`. A temperature write in the same cycle as a pop that takes the old value leaves the new value held.
- R7: A conversion write while `fillLevel` is 16 and no pop is served drops the oldest queued result and keeps `fillLevel` at 16.
- R8: A pop and a conversion write in the same cycle act together. The pop sees the contents from before that cycle, and `fillLevel` does not change when the pop takes from the queue.
- R9: `flush` overrides any write or pop in the same cycle.
- R10: `fillLevel` rises by one per conversion write and falls by one per pop served from the queue. It never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of queue and temperature slot |
| wrValid | input | 1 | Write strobe from the converter |
| wrIsTemp | input | 1 | 1: the write is a temperature result |
| wrData | input | 12 | Result value |
| popReq | input | 1 | One-cycle request at the start of a read transaction |
| outWord | output | 16 | Word presented for serial readout |
| fillLevel | output | 5 | Number of conversion results in the queue |
| tempHeld | output | 1 | An unread temperature result is present |

## Verification
On every cycle the assertions check four things: the four zero padding bits, the bound on `fillLevel`, the hold of `outWord` between pops, and the state after a flush. On a bounded step they also check that an empty pop yields zero, that a temperature pop clears the slot, and that a write into a full queue keeps it full. Only the bench scenarios can show the data side. That covers FIFO order across the full-queue overwrite, which entry the overwrite drops, temperature priority over pending results, replacement of an unread temperature value, and same-cycle push and pop at both empty and full. The bench compares against its behavioural model on every clock.

// File: rtl/cr_fifo_pkg.sv
package cr_fifo_pkg;
  typedef enum logic [1:0] {
    SEL_ZERO  = 2'd0,
    SEL_QUEUE = 2'd1,
    SEL_TEMP  = 2'd2
  } outSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    clear;
    logic    pushQ;
    logic    loadTemp;
    logic    loadOut;
    outSel_e outSel;
  } rfStrobe_t;
endpackage

// File: rtl/cr_fifo_ctrl.sv
module cr_fifo_ctrl
  import cr_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             wrValid,
  input  logic             wrIsTemp,
  input  logic             popReq,
  output rfStrobe_t        strb,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic [CNT_W-1:0] fillLevel,
  output logic             tempHeld
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             tempValid;
  logic qEmpty, qFull, popTemp, popQ, pushQ, loadTemp, advRd;

  function automatic logic [PTR_W-1:0] nextIdx(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    qEmpty   = (count == '0);
    qFull    = (count == FULL_CNT);
    popTemp  = popReq && tempValid;
    popQ     = popReq && !tempValid && !qEmpty;
    pushQ    = wrValid && !wrIsTemp;
    loadTemp = wrValid && wrIsTemp;
    advRd    = popQ || (pushQ && qFull);

    strb.clear    = flush;
    strb.pushQ    = pushQ && !flush;
    strb.loadTemp = loadTemp && !flush;
    strb.loadOut  = popReq;
    if (popTemp)   strb.outSel = SEL_TEMP;
    else if (popQ) strb.outSel = SEL_QUEUE;
    else           strb.outSel = SEL_ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      tempValid <= 1'b0;
    end else if (flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      tempValid <= 1'b0;
    end else begin
      if (pushQ) wrPtr <= nextIdx(wrPtr);
      if (advRd) rdPtr <= nextIdx(rdPtr);
      if (pushQ && !popQ && !qFull) count <= count + 1'b1;
      else if (popQ && !pushQ)      count <= count - 1'b1;
      if (loadTemp)     tempValid <= 1'b1;
      else if (popTemp) tempValid <= 1'b0;
    end
  end

  assign wrIdx     = wrPtr;
  assign rdIdx     = rdPtr;
  assign fillLevel = count;
  assign tempHeld  = tempValid;
endmodule

// File: rtl/cr_fifo_dpath.sv
module cr_fifo_dpath
  import cr_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12,
  parameter int WORD_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int PAD_W = WORD_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         strb,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [WORD_W-1:0] outWord
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] tempReg;
  logic [WORD_W-1:0] outReg;
  logic [DATA_W-1:0] picked;

  always_comb begin
    unique case (strb.outSel)
      SEL_TEMP:  picked = tempReg;
      SEL_QUEUE: picked = mem[rdIdx];
      default:   picked = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.pushQ) mem[wrIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempReg <= '0;
      outReg  <= '0;
    end else if (strb.clear) begin
      tempReg <= '0;
      outReg  <= '0;
    end else begin
      if (strb.loadTemp) tempReg <= wrData;
      if (strb.loadOut)  outReg  <= {{PAD_W{1'b0}}, picked};
    end
  end

  assign outWord = outReg;
endmodule

// File: rtl/conv_result_fifo.sv
module conv_result_fifo
  import cr_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12,
  parameter int WORD_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              wrValid,
  input  logic              wrIsTemp,
  input  logic [DATA_W-1:0] wrData,
  input  logic              popReq,
  output logic [WORD_W-1:0] outWord,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              tempHeld
);
  rfStrobe_t        strb;
  logic [PTR_W-1:0] wrIdx, rdIdx;

  cr_fifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .wrValid(wrValid),
    .wrIsTemp(wrIsTemp), .popReq(popReq), .strb(strb),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .fillLevel(fillLevel), .tempHeld(tempHeld)
  );

  cr_fifo_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .WORD_W(WORD_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrData(wrData), .outWord(outWord)
  );
endmodule

// File: rtl/conv_result_fifo_chk.sv
module conv_result_fifo_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12,
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              flush,
  input logic              wrValid,
  input logic              wrIsTemp,
  input logic [DATA_W-1:0] wrData,
  input logic              popReq,
  input logic [WORD_W-1:0] outWord,
  input logic [CNT_W-1:0]  fillLevel,
  input logic              tempHeld
);
  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outWord[WORD_W-1:DATA_W] == '0);

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(DEPTH));

  // R1
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (fillLevel == '0 && !tempHeld && outWord == '0));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!popReq && !flush) |=> $stable(outWord));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !flush && !wrValid && fillLevel == '0 && !tempHeld)
      |=> (outWord == '0 && fillLevel == '0));

  // R5
  temp_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && tempHeld && !flush && !wrValid) |=> !tempHeld);

  // R7
  full_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrIsTemp && !flush && fillLevel == CNT_W'(DEPTH))
      |=> fillLevel == CNT_W'(DEPTH));
endmodule

bind conv_result_fifo conv_result_fifo_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .WORD_W(WORD_W)) uChk (.*);

// File: tb/tb_conv_result_fifo.sv
module tb_conv_result_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0, wrValid = 1'b0, wrIsTemp = 1'b0, popReq = 1'b0;
  logic [11:0] wrData = '0;
  logic [15:0] outWord;
  logic [4:0]  fillLevel;
  logic        tempHeld;

  int checks = 0;
  int errors = 0;

  logic [11:0] modelQ[$];
  logic        mTv = 1'b0;
  logic [11:0] mTval = '0;
  logic [15:0] mOut = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_result_fifo dut (
    .clk(clk), .rstN(rstN), .flush(flush), .wrValid(wrValid),
    .wrIsTemp(wrIsTemp), .wrData(wrData), .popReq(popReq),
    .outWord(outWord), .fillLevel(fillLevel), .tempHeld(tempHeld)
  );

  task automatic compare(input string tag);
    checks++;
    if (outWord !== mOut || fillLevel !== 5'(modelQ.size()) || tempHeld !== mTv) begin
      errors++;
      $display("FAIL %s: out=%h fill=%0d temp=%0d expected out=%h fill=%0d temp=%0d",
               tag, outWord, fillLevel, tempHeld, mOut, modelQ.size(), mTv);
    end
  endtask

  task automatic step(input logic wv, input logic wt, input logic [11:0] wd,
                      input logic pop, input logic fl, input string tag);
    wrValid = wv; wrIsTemp = wt; wrData = wd; popReq = pop; flush = fl;
    @(posedge clk);
    if (fl) begin
      modelQ.delete(); mTv = 1'b0; mOut = '0;
    end else begin
      if (pop) begin
        if (mTv) begin mOut = {4'b0, mTval}; mTv = 1'b0; end
        else if (modelQ.size() > 0) mOut = {4'b0, modelQ.pop_front()};
        else mOut = '0;
      end
      if (wv && wt) begin mTv = 1'b1; mTval = wd; end
      else if (wv) begin
        if (modelQ.size() == DEPTH) void'(modelQ.pop_front());
        modelQ.push_back(wd);
      end
    end
    #1;
    compare(tag);
    wrValid = 1'b0; popReq = 1'b0; flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R3 / R10: ordered readout
    for (int i = 0; i < 3; i++) step(1, 0, 12'hA00 + 12'(i), 0, 0, "R10 push");
    for (int i = 0; i < 3; i++) step(0, 0, '0, 1, 0, "R2 order");
    // R4: empty pop
    step(0, 0, '0, 1, 0, "R4 empty pop");
    step(0, 0, '0, 0, 0, "R2 hold");
    // R7: overwrite oldest
    for (int i = 0; i < 19; i++) step(1, 0, 12'(100 + i), 0, 0, "R7 overwrite");
    // R8: push and pop together at full
    step(1, 0, 12'hFFF, 1, 0, "R8 full push+pop");
    for (int i = 0; i < 16; i++) step(0, 0, '0, 1, 0, "R7 drain order");
    step(0, 0, '0, 1, 0, "R4 drained");
    // R8: push and pop together at empty
    step(1, 0, 12'h123, 1, 0, "R8 empty push+pop");
    step(0, 0, '0, 1, 0, "R8 follow pop");
    // R5: temperature first
    step(1, 0, 12'h011, 0, 0, "R10 push");
    step(1, 1, 12'h7C8, 0, 0, "R5 temp load");
    step(0, 0, '0, 1, 0, "R5 temp first");
    step(0, 0, '0, 1, 0, "R5 then queue");
    // R6: replacement
    step(1, 1, 12'h111, 0, 0, "R6 temp a");
    step(1, 1, 12'h222, 0, 0, "R6 temp b");
    step(1, 1, 12'h333, 1, 0, "R6 pop with new temp");
    step(0, 0, '0, 1, 0, "R6 newest held");
    // R9: flush wins
    step(1, 0, 12'h044, 0, 0, "R10 push");
    step(1, 1, 12'h055, 0, 0, "R9 temp");
    step(1, 0, 12'h066, 1, 1, "R9 flush dominates");
    step(0, 0, '0, 1, 0, "R9 empty after flush");
    // R10: random mix
    for (int i = 0; i < 400; i++)
      step(1'($urandom), 1'(($urandom % 8) == 0), 12'($urandom),
           1'($urandom), 1'(($urandom % 50) == 0), "R10 random");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule